// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Host Sequencer

This block sits on the host side of a multichannel converter that samples all of its inputs at the same instant and returns 14-bit results over a shared parallel bus. When `start` is pulsed, the block writes an 8-bit channel-select byte into the converter and raises convert-start, which freezes every input at once. It then watches two completion lines from the converter. The first is a short per-channel pulse. The second is a flag that stays low once the last channel is done, until convert-start drops again.

Each per-channel pulse is turned into one two-cycle read on the bus. Every captured word leaves the block on a valid/data stream, tagged with its channel index, with the active channels in ascending order. When every expected word has been read and the last-conversion flag is low, convert-start is lowered. Lowering it re-arms the flag, and the block returns to idle. A programmable timeout abandons a sequence that never finishes and latches an error bit. A separate enable-all input overrides the select byte, so that every channel takes part.

Top module: `adc_sample_sequencer`

## Requirements
- R1: A `start` pulse seen while idle produces exactly one write cycle in which `adcCsN` and `adcWrN` are low, `adcRdN` is high, `adcDataOe` is high and `adcDataOut` carries the captured `cfgByte` in bits 7:0 with zeros above; bit i of the byte set means channel i is active.
- R2: `adcDataOe` is high only during the write cycle, and `adcRdN` is never low in a cycle where `adcDataOe` is high or was high the cycle before.
- R3: When at least one channel is active, `adcConvst` rises exactly two cycles after the write cycle (write, one released-bus cycle, then convert-start) and stays high until the sequence ends.
- R4: Every high-to-low transition of `adcEocN` while convert-start is high counts as one finished conversion, whatever the low width, and each one leads to exactly one read with `adcCsN` and `adcRdN` low for exactly two cycles; transitions that arrive during a read are queued, not lost.
- R5: The bus word present at the end of the second read cycle appears on `resData` with `resValid` high for one cycle in the next cycle; `resChan` gives the active channels in ascending order, lowest first.
- R6: The sequence ends only when every active channel has been read and `adcEolcN` is low; a low `adcEolcN` that arrives while reads are still owed does not cut the sequence short. At the end `adcConvst` and `busy` are low.
- R7: With `cfgAllOn` high at start, all NCH channels are read whatever the select byte, and `adcAllOn` is high during the conversion.
- R8: A select byte of zero with `cfgAllOn` low performs the write, never raises `adcConvst`, produces no result and returns to idle.
- R9: If the sequence has not ended when `adcConvst` has been high for `timeoutLimit`+1 cycles with no read pending, `adcConvst` drops, the block goes idle and `errTimeout` goes high. The timeout takes priority over a pending read. `errTimeout` stays high until the next accepted start clears it.
- R10: `start` pulses that arrive while `busy` is high are ignored: no second write takes place and the result stream of the running sequence is unchanged.
- R11: While reset is held, `adcCsN`, `adcWrN` and `adcRdN` are high, and `adcConvst`, `adcDataOe`, `busy`, `errTimeout` and `resValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only while idle) |
| cfgByte | input | 8 | Channel-select byte, bit i enables channel i |
| cfgAllOn | input | 1 | Override: every channel active |
| timeoutLimit | input | TW (16) | Timeout in clocks of convert-start high |
| busy | output | 1 | Sequence in progress |
| errTimeout | output | 1 | Last sequence was abandoned by the timeout |
| resValid | output | 1 | One-cycle result strobe |
| resChan | output | CW (3) | Channel index of the result |
| resData | output | DW (14) | Result word |
| adcCsN | output | 1 | Converter chip select, active low |
| adcWrN | output | 1 | Converter write strobe, active low |
| adcRdN | output | 1 | Converter read strobe, active low |
| adcConvst | output | 1 | Convert-start, high holds and converts |
| adcAllOn | output | 1 | Enable-all line to the converter |
| adcEocN | input | 1 | Per-channel end-of-conversion, active low |
| adcEolcN | input | 1 | Last-conversion flag, active low and sticky |
| adcDataIn | input | DW (14) | Bus value read from the converter |
| adcDataOut | output | DW (14) | Bus value driven toward the converter |
| adcDataOe | output | 1 | Host drives the bus when high |

## Verification
The bench builds the block with its defaults: eight channels, a 14-bit bus, an 8-bit select byte and a 16-bit timeout. With eight channels, full select bytes and the enable-all override can be used, so the channel-ordering logic has to walk every bit position, including the top and bottom bits alone. A 16-bit timeout field allows a generous limit for normal runs and a short limit of 40 for the stalled run. The burst pattern of the converter model places end-of-conversion edges closer together than a read lasts. This drives the pending-count path, and it lowers the last-conversion flag while reads are still owed.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_GAP,
    S_CONV,
    S_RD1,
    S_RD2
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCfg;   // latch select byte and override, clear error
    logic clrRun;    // reset per-sequence counters and channel mask
    logic capture;   // take the bus word as a result
    logic runTick;   // convert-start is high this cycle
    logic abort;     // timeout abandoned the sequence
  } seqStrobe_t;

endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 14,
  parameter int CFGW = 8,
  parameter int TW   = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NW  = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strb,
  input  logic [CFGW-1:0] cfgByte,
  input  logic            cfgAllOn,
  input  logic [TW-1:0]   timeoutLimit,
  input  logic            eocN,
  input  logic [DW-1:0]   busIn,
  output logic            activeZero,
  output logic            pending,
  output logic            readsDone,
  output logic            timedOut,
  output logic [DW-1:0]   cfgOut,
  output logic            allOnOut,
  output logic            resValid,
  output logic [CW-1:0]   resChan,
  output logic [DW-1:0]   resData,
  output logic            errTimeout
);

  logic [CFGW-1:0] cfgReg;
  logic            allOnReg;
  logic [NCH-1:0]  activeMask;
  logic [NCH-1:0]  remMask;
  logic [NW-1:0]   activeCnt;
  logic [NW-1:0]   eocCnt;
  logic [NW-1:0]   rdCnt;
  logic [CW-1:0]   lowIdx;
  logic [TW-1:0]   timer;
  logic            eocPrev;
  logic            eocFall;

  assign activeMask = allOnReg ? {NCH{1'b1}} : cfgReg[NCH-1:0];
  assign eocFall    = eocPrev & ~eocN;

  always_comb begin
    activeCnt = '0;
    for (int i = 0; i < NCH; i++) activeCnt = activeCnt + NW'(activeMask[i]);
  end

  // lowest remaining channel gives ascending order
  always_comb begin
    lowIdx = '0;
    for (int i = NCH - 1; i >= 0; i--) if (remMask[i]) lowIdx = CW'(i);
  end

  generate
    if (DW > CFGW) begin : g_pad
      assign cfgOut = {{(DW - CFGW){1'b0}}, cfgReg};
    end else begin : g_trunc
      assign cfgOut = cfgReg[DW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg     <= '0;
      allOnReg   <= 1'b0;
      remMask    <= '0;
      eocCnt     <= '0;
      rdCnt      <= '0;
      timer      <= '0;
      eocPrev    <= 1'b1;
      resValid   <= 1'b0;
      resChan    <= '0;
      resData    <= '0;
      errTimeout <= 1'b0;
    end else begin
      eocPrev  <= eocN;
      resValid <= 1'b0;
      if (strb.loadCfg) begin
        cfgReg     <= cfgByte;
        allOnReg   <= cfgAllOn;
        errTimeout <= 1'b0;
      end
      if (strb.clrRun) begin
        remMask <= activeMask;
        eocCnt  <= '0;
        rdCnt   <= '0;
        timer   <= '0;
      end
      if (strb.runTick) begin
        if (timer != {TW{1'b1}}) timer <= timer + 1'b1;
        if (eocFall && (eocCnt < activeCnt)) eocCnt <= eocCnt + 1'b1;
      end
      if (strb.capture) begin
        resValid        <= 1'b1;
        resData         <= busIn;
        resChan         <= lowIdx;
        remMask[lowIdx] <= 1'b0;
        rdCnt           <= rdCnt + 1'b1;
      end
      if (strb.abort) errTimeout <= 1'b1;
    end
  end

  assign activeZero = (activeCnt == '0);
  assign pending    = (eocCnt > rdCnt);
  assign readsDone  = (rdCnt == activeCnt);
  assign timedOut   = (timer >= timeoutLimit);
  assign allOnOut   = allOnReg;

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       activeZero,
  input  logic       pending,
  input  logic       readsDone,
  input  logic       timedOut,
  input  logic       eolcN,
  output seqStrobe_t strb,
  output logic       csN,
  output logic       wrN,
  output logic       rdN,
  output logic       busOe,
  output logic       convst,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadCfg = 1'b1;
          nextState    = S_WRITE;
        end
      end
      S_WRITE: nextState = S_GAP;
      S_GAP: begin
        strb.clrRun = 1'b1;
        nextState   = activeZero ? S_IDLE : S_CONV;
      end
      S_CONV: begin
        strb.runTick = 1'b1;
        if (timedOut) begin
          strb.abort = 1'b1;
          nextState  = S_IDLE;
        end else if (pending) begin
          nextState = S_RD1;
        end else if (readsDone && !eolcN) begin
          nextState = S_IDLE;
        end
      end
      S_RD1: begin
        strb.runTick = 1'b1;
        nextState    = S_RD2;
      end
      S_RD2: begin
        strb.runTick = 1'b1;
        strb.capture = 1'b1;
        nextState    = S_CONV;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    wrN    = (state != S_WRITE);
    rdN    = !((state == S_RD1) || (state == S_RD2));
    csN    = wrN && rdN;
    busOe  = (state == S_WRITE);
    convst = (state == S_CONV) || (state == S_RD1) || (state == S_RD2);
    busy   = (state != S_IDLE);
  end

endmodule

// File: rtl/adc_sample_sequencer.sv
module adc_sample_sequencer
  import adcseq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 14,
  parameter int CFGW = 8,
  parameter int TW   = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CFGW-1:0] cfgByte,
  input  logic            cfgAllOn,
  input  logic [TW-1:0]   timeoutLimit,
  output logic            busy,
  output logic            errTimeout,
  output logic            resValid,
  output logic [CW-1:0]   resChan,
  output logic [DW-1:0]   resData,
  output logic            adcCsN,
  output logic            adcWrN,
  output logic            adcRdN,
  output logic            adcConvst,
  output logic            adcAllOn,
  input  logic            adcEocN,
  input  logic            adcEolcN,
  input  logic [DW-1:0]   adcDataIn,
  output logic [DW-1:0]   adcDataOut,
  output logic            adcDataOe
);

  seqStrobe_t strb;
  logic activeZero, pending, readsDone, timedOut;

  adcseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .activeZero(activeZero), .pending(pending), .readsDone(readsDone),
    .timedOut(timedOut), .eolcN(adcEolcN), .strb(strb),
    .csN(adcCsN), .wrN(adcWrN), .rdN(adcRdN), .busOe(adcDataOe),
    .convst(adcConvst), .busy(busy)
  );

  adcseq_datapath #(.NCH(NCH), .DW(DW), .CFGW(CFGW), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgByte(cfgByte), .cfgAllOn(cfgAllOn), .timeoutLimit(timeoutLimit),
    .eocN(adcEocN), .busIn(adcDataIn),
    .activeZero(activeZero), .pending(pending), .readsDone(readsDone),
    .timedOut(timedOut), .cfgOut(adcDataOut), .allOnOut(adcAllOn),
    .resValid(resValid), .resChan(resChan), .resData(resData),
    .errTimeout(errTimeout)
  );

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic errTimeout,
  input logic resValid,
  input logic adcCsN,
  input logic adcWrN,
  input logic adcRdN,
  input logic adcConvst,
  input logic adcDataOe
);

  p_write_cycle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !adcWrN |-> (!adcCsN && adcDataOe && adcRdN));

  p_oe_only_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcDataOe |-> !adcWrN);

  p_bus_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    !adcRdN |-> (!adcDataOe && !$past(adcDataOe)));

  p_convst_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    adcConvst |-> busy);

  p_read_two_cycles_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcRdN) |=> (!adcRdN && !adcCsN));

  p_result_after_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(!adcRdN));

  p_abort_drops_convst_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> (!adcConvst && !busy));

endmodule

bind adc_sample_sequencer adcseq_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .errTimeout(errTimeout),
  .resValid(resValid), .adcCsN(adcCsN), .adcWrN(adcWrN), .adcRdN(adcRdN),
  .adcConvst(adcConvst), .adcDataOe(adcDataOe)
);

// File: tb/tb_adc_sample_sequencer.sv
`timescale 1ns/1ps
module tb_adc_sample_sequencer;

  localparam int NCH = 8;
  localparam int DW  = 14;

  typedef struct { int chan; logic [DW-1:0] data; } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] cfgByte = '0;
  logic cfgAllOn = 1'b0;
  logic [15:0] timeoutLimit = 16'd500;
  logic busy, errTimeout, resValid;
  logic [2:0] resChan;
  logic [DW-1:0] resData;
  logic adcCsN, adcWrN, adcRdN, adcConvst, adcAllOn, adcDataOe;
  logic adcEocN = 1'b1;
  logic adcEolcN = 1'b1;
  logic [DW-1:0] adcDataIn = '0;
  logic [DW-1:0] adcDataOut;

  always #2.5 clk = ~clk;

  adc_sample_sequencer dut (.*);

  int checks = 0, fails = 0;
  int cyc = 0, runIdx = 0;
  // converter model settings and per-run observations
  int mLat = 6, mGap = 8, mW = 3, nAct = 0, tick = 0;
  bit stallMode = 0, converting = 0, convPrev = 0, rdPrev = 0, oePrev = 0;
  int wrCount, wrCyc, riseCyc, convHigh, readStarts, rdLen, rdLenBad, overlapBad, resSeen;
  bit allOnSeen;
  logic [7:0] curCfg;
  int chanList[$];
  logic [DW-1:0] dataQ[$];
  expItem_t expQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sampleVal(input int k);
    return DW'((runIdx * 37 + chanList[k] * 1021 + 5) & 'h3FFF);
  endfunction

  // converter model and monitors, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!adcWrN && !adcCsN) begin
        wrCount++;
        wrCyc = cyc;
        chk(adcDataOe && (adcDataOut == {6'b0, curCfg}), "R1", "write bus value",
            adcDataOut, {6'b0, curCfg});
      end
      if (!adcRdN && (adcDataOe || oePrev)) overlapBad++;
      oePrev = adcDataOe;
      if (adcConvst) begin
        convHigh++;
        if (adcAllOn) allOnSeen = 1;
      end
      if (adcConvst && !convPrev) begin
        riseCyc = cyc; converting = 1; tick = 0; dataQ.delete();
      end
      if (!adcConvst && convPrev) begin
        converting = 0; adcEolcN = 1'b1; adcEocN = 1'b1;
      end
      convPrev = adcConvst;
      if (converting) begin
        adcEocN = 1'b1;
        if (!stallMode) begin
          int rel;
          rel = tick - mLat;
          if (rel >= 0 && rel / mGap < nAct) begin
            if (rel % mGap < mW) adcEocN = 1'b0;
            if (rel % mGap == 0) begin
              int k;
              logic [DW-1:0] v;
              k = rel / mGap;
              v = sampleVal(k);
              dataQ.push_back(v);
              expQ.push_back('{chanList[k], v});
              if (k == nAct - 1) adcEolcN = 1'b0;
            end
          end
        end
        tick++;
      end
      if (!adcCsN && !adcRdN) begin
        if (!rdPrev) begin
          readStarts++;
          rdLen = 0;
          adcDataIn = (dataQ.size() > 0) ? dataQ.pop_front() : 14'h3FFF;
        end
        rdLen++;
      end else begin
        if (rdPrev && rdLen != 2) rdLenBad++;
        adcDataIn = '0;
      end
      rdPrev = !adcCsN && !adcRdN;
      if (resValid) begin
        resSeen++;
        if (expQ.size() == 0) chk(0, "R5", "unexpected result chan", resChan, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(resChan == e.chan, "R5", "result channel", resChan, e.chan);
          chk(resData == e.data, "R4", "result data", resData, e.data);
        end
      end
    end
  end

  task automatic runSeq(input logic [7:0] cfg, input bit allOn, input int lat,
                        input int gap, input int w, input bit stall,
                        input logic [15:0] limit, input bit extraStart);
    int n;
    @(negedge clk); #1;
    runIdx++;
    chanList.delete(); expQ.delete();
    for (int ch = 0; ch < NCH; ch++) if (allOn || cfg[ch]) chanList.push_back(ch);
    nAct = chanList.size();
    mLat = lat; mGap = gap; mW = w; stallMode = stall; curCfg = cfg;
    wrCount = 0; convHigh = 0; readStarts = 0; rdLenBad = 0; overlapBad = 0;
    resSeen = 0; allOnSeen = 0; wrCyc = 0; riseCyc = 0;
    cfgByte = cfg; cfgAllOn = allOn; timeoutLimit = limit; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk); #1;
      n++;
      if (extraStart && n == 10) begin start = 1'b1; cfgByte = 8'h01; end
      if (extraStart && n == 11) start = 1'b0;
    end
    chk(!busy, "R6", "sequence finished", busy, 0);
    chk(wrCount == 1, "R10", "write count", wrCount, 1);
    chk(overlapBad == 0, "R2", "read overlapping driven bus", overlapBad, 0);
    chk(!adcConvst, "R6", "convst low at end", adcConvst, 0);
    if (stall) begin
      chk(errTimeout, "R9", "timeout flag", errTimeout, 1);
      chk(convHigh == limit + 1, "R9", "convst high cycles", convHigh, limit + 1);
      chk(resSeen == 0, "R9", "results on abort", resSeen, 0);
    end else begin
      chk(!errTimeout, "R9", "no timeout", errTimeout, 0);
      chk(resSeen == nAct, "R6", "result count", resSeen, nAct);
      chk(expQ.size() == 0, "R5", "results outstanding", expQ.size(), 0);
      chk(readStarts == nAct, "R4", "read count", readStarts, nAct);
      chk(rdLenBad == 0, "R4", "read length", rdLenBad, 0);
    end
    if (nAct == 0) chk(convHigh == 0, "R8", "convst with no channel", convHigh, 0);
    else chk(riseCyc == wrCyc + 2, "R3", "convst rise cycle", riseCyc, wrCyc + 2);
    if (allOn) chk(allOnSeen, "R7", "enable-all line", allOnSeen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(adcCsN && adcWrN && adcRdN, "R11", "strobes high in reset",
        {adcCsN, adcWrN, adcRdN}, 3'b111);
    chk(!adcConvst && !adcDataOe && !busy && !errTimeout && !resValid, "R11",
        "idle outputs in reset",
        {adcConvst, adcDataOe, busy, errTimeout, resValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runSeq(8'hA5, 0, 6, 8, 3, 0, 16'd500, 0);
    runSeq(8'h01, 0, 6, 8, 3, 0, 16'd500, 0);
    runSeq(8'h80, 0, 5, 7, 2, 0, 16'd500, 0);
    runSeq(8'h00, 1, 6, 8, 3, 0, 16'd500, 0);   // R7 override
    runSeq(8'hFF, 0, 4, 2, 1, 0, 16'd500, 0);   // R4 R6 burst, flag early
    runSeq(8'h00, 0, 6, 8, 3, 0, 16'd500, 0);   // R8 nothing selected
    runSeq(8'h0F, 0, 6, 8, 3, 1, 16'd40, 0);    // R9 stalled converter
    repeat (5) @(negedge clk);
    chk(errTimeout, "R9", "flag held while idle", errTimeout, 1);
    runSeq(8'h3C, 0, 6, 8, 3, 0, 16'd500, 1);   // R10 start while busy
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule